// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor reach the management registers of external PHY devices over a two-wire serial bus. Software sees four 32-bit words behind a small write/read port. A setup word holds the serial clock divisor and a master enable. A command word names the target device and register, selects read or write, and launches the exchange. The other two words hold the outgoing and the returned 16-bit values. The block divides the host clock down to the management clock and shifts one complete clause-22 frame. On reads it releases the data line and collects the reply.

Software puts the outgoing value in place first. It then writes one command word with a single operation bit and the launch bit set, and polls the ready flag in that same word. Once ready is back, a read result can be fetched from the returned-value word. Command writes made while an exchange is in flight are dropped. Malformed commands never leave the idle state.

Word offsets on the 2-bit address: 0 setup, 1 command, 2 outgoing value, 3 returned value.

Top module: `mdio_master`

## Requirements
- R1: After reset the setup word reads 0x0000001D (divisor 29, enable bit 6 clear), the command word reads 0x00000080 (only ready, bit 7, set), the returned-value word reads 0, and mdc, mdio_oe are low.
- R2: A command write stores the device address in bits 28:24, the register address in bits 20:16, the read request in bit 15 and the write request in bit 14, and all four read back in place; the launch bit 11 always reads 0.
- R3: A command write with bit 11 set, exactly one of bits 15/14 set and the enable bit set, made while ready is 1, clears ready (bit 7) from the very next clock cycle.
- R4: Every frame shifts, MSB first, 32 ones, start pattern 0 then 1, opcode 1,0 for read or 0,1 for write, the 5-bit device address and the 5-bit register address.
- R5: In a write frame the master drives turnaround 1,0 and then the 16 outgoing bits MSB first, with mdio_oe high for all 64 bit periods.
- R6: In a read frame mdio_oe is low from the turnaround on. The 16 bits present on mdio_i at the rising mdc edges of the data phase appear MSB first in bits 15:0 of the returned-value word by the time ready is back.
- R7: mdc has a period of 2*(divisor+1) host cycles, mdio_o and mdio_oe change only while mdc falls or while it is low, and mdc stays low while ready is 1.
- R8: Ready returns only after the last data bit and one further full mdc period with mdio_oe low, so each exchange shows exactly 65 rising mdc edges; mdio_oe is low whenever ready is 1.
- R9: A command write during an exchange is ignored: the frame in progress is unchanged and the stored command fields keep their values.
- R10: A launch with both operation bits set or with neither set starts nothing: ready stays 1 and mdc does not toggle.
- R11: With the enable bit clear a launch starts nothing: ready stays 1 and mdc does not toggle.
- R12: With the reset divisor an exchange completes within 25,000 host cycles (200 us at 125 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register word address for reads |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
Ready falls one host cycle after the command write's clock edge, so the bench reads the command word at the falling clock edge right after the write. Frame bits are due at rising mdc edges, at multiples of divisor+1 host cycles after launch. The bench records mdio_o and mdio_oe on every rising mdc edge and compares them with a frame built from the requirements. The returned value and the 65-edge count are checked only once ready has come back, about 130*(divisor+1) cycles after launch. Negative cases wait a fixed number of cycles and then confirm that no mdc edge has occurred.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int FRAME_LEN = 64;
    localparam int DATA_LEN  = 16;

    localparam logic [1:0] ADDR_CFG   = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_WDATA = 2'd2;
    localparam logic [1:0] ADDR_RDATA = 2'd3;

    localparam int CTL_PHY_LSB = 24;
    localparam int CTL_REG_LSB = 16;
    localparam int CTL_RD_BIT  = 15;
    localparam int CTL_WR_BIT  = 14;
    localparam int CTL_GO_BIT  = 11;
    localparam int CTL_RDY_BIT = 7;
    localparam int CFG_EN_BIT  = 6;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_SHIFT, SEQ_TAIL} seq_state_e;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regad;
        logic       is_read;
    } mdio_req_t;

    // serial image of one clause-22 frame, first bit in the MSB
    function automatic logic [FRAME_LEN-1:0] frame_bits(mdio_req_t q, logic [DATA_LEN-1:0] wd);
        frame_bits = {32'hFFFF_FFFF, 2'b01, (q.is_read ? 2'b10 : 2'b01), q.phy, q.regad,
                      (q.is_read ? 2'b00 : 2'b10), (q.is_read ? 16'h0000 : wd)};
    endfunction

    // which frame bits the master drives
    function automatic logic [FRAME_LEN-1:0] drive_mask(logic is_read);
        drive_mask = is_read ? {{46{1'b1}}, 18'b0} : {FRAME_LEN{1'b1}};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = run && (cnt == div);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  mdio_req_t           req,
    input  logic [DATA_LEN-1:0] wdata,
    input  logic                rise_stb,
    input  logic                fall_stb,
    input  logic                mdio_i,
    output logic                busy,
    output logic                done,
    output logic                mdio_o,
    output logic                mdio_oe,
    output logic [DATA_LEN-1:0] capture
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam int DATA_FIRST = FRAME_LEN - DATA_LEN;

    seq_state_e           state;
    logic [FRAME_LEN-1:0] shreg;
    logic [FRAME_LEN-1:0] oereg;
    logic [IDX_W-1:0]     idx;

    assign busy = (state != SEQ_IDLE);
    assign done = (state == SEQ_TAIL) && fall_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            shreg   <= '0;
            oereg   <= '0;
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            capture <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    shreg   <= frame_bits(req, wdata);
                    oereg   <= drive_mask(req.is_read);
                    mdio_o  <= frame_bits(req, wdata) >> (FRAME_LEN - 1);
                    mdio_oe <= drive_mask(req.is_read) >> (FRAME_LEN - 1);
                    idx     <= '0;
                    state   <= SEQ_SHIFT;
                end
                SEQ_SHIFT: begin
                    if (rise_stb && (int'(idx) >= DATA_FIRST))
                        capture <= {capture[DATA_LEN-2:0], mdio_i};
                    if (fall_stb) begin
                        if (int'(idx) == FRAME_LEN - 1) begin
                            mdio_oe <= 1'b0;
                            state   <= SEQ_TAIL;
                        end else begin
                            idx     <= idx + 1'b1;
                            shreg   <= shreg << 1;
                            oereg   <= oereg << 1;
                            mdio_o  <= shreg[FRAME_LEN-2];
                            mdio_oe <= oereg[FRAME_LEN-2];
                        end
                    end
                end
                SEQ_TAIL: if (fall_stb) begin
                    mdio_o <= 1'b1;
                    state  <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int DIV_RESET = 29
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0]    cfg_div_q;
    logic                cfg_en_q;
    mdio_req_t           req_q;
    logic [1:0]          op_q;
    logic [DATA_LEN-1:0] wdata_q;
    logic [DATA_LEN-1:0] rdata_q;
    logic                busy, done, rise_stb, fall_stb, ready;
    logic [DATA_LEN-1:0] capture;
    logic                ctrl_wr, go;
    mdio_req_t           new_req;

    assign ready   = !busy;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL) && ready;
    assign go      = ctrl_wr && wr_data[CTL_GO_BIT] && cfg_en_q &&
                     (wr_data[CTL_RD_BIT] ^ wr_data[CTL_WR_BIT]);
    assign new_req = '{phy:     wr_data[CTL_PHY_LSB +: 5],
                       regad:   wr_data[CTL_REG_LSB +: 5],
                       is_read: wr_data[CTL_RD_BIT]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_div_q <= DIV_W'(DIV_RESET);
            cfg_en_q  <= 1'b0;
            req_q     <= '0;
            op_q      <= 2'b00;
            wdata_q   <= '0;
            rdata_q   <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_CFG) begin
                cfg_div_q <= wr_data[DIV_W-1:0];
                cfg_en_q  <= wr_data[CFG_EN_BIT];
            end
            if (wr_en && wr_addr == ADDR_WDATA)
                wdata_q <= wr_data[DATA_LEN-1:0];
            if (ctrl_wr) begin
                req_q <= new_req;
                op_q  <= {wr_data[CTL_RD_BIT], wr_data[CTL_WR_BIT]};
            end
            if (done && req_q.is_read)
                rdata_q <= capture;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CFG: begin
                rd_data[DIV_W-1:0]  = cfg_div_q;
                rd_data[CFG_EN_BIT] = cfg_en_q;
            end
            ADDR_CTRL: begin
                rd_data[CTL_PHY_LSB +: 5] = req_q.phy;
                rd_data[CTL_REG_LSB +: 5] = req_q.regad;
                rd_data[CTL_RD_BIT]       = op_q[1];
                rd_data[CTL_WR_BIT]       = op_q[0];
                rd_data[CTL_RDY_BIT]      = ready;
            end
            ADDR_WDATA: rd_data[DATA_LEN-1:0] = wdata_q;
            default:    rd_data[DATA_LEN-1:0] = rdata_q;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .run(busy), .div(cfg_div_q),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_seq u_seq (
        .clk(clk), .rst(rst), .start(go), .req(new_req), .wdata(wdata_q),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .capture(capture)
    );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        ready,
    input logic        cfg_en,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data[11] && (wr_data[15] ^ wr_data[14]) && cfg_en && ready)
        |=> !ready);
    // R10
    bad_op_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data[11] && (wr_data[15] == wr_data[14]) && ready)
        |=> ready);
    // R11
    disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && !cfg_en && ready) |=> ready);
    // R7
    mdc_idle_chk: assert property (@(posedge clk) disable iff (rst) ready |-> !mdc);
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst) mdc |-> $stable(mdio_o));
    // R7
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst) mdc |-> $stable(mdio_oe));
    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (rst) ready |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready(ready), .cfg_en(cfg_en_q), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd1;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records what the master presents at each rising mdc edge
    int          ncap = 0;
    logic        cap_o  [0:79];
    logic        cap_oe [0:79];
    longint      cap_t  [0:79];
    logic [15:0] phy_val = 16'h0;

    always @(posedge mdc) begin
        if (ncap < 80) begin
            cap_o[ncap]  = mdio_o;
            cap_oe[ncap] = mdio_oe;
            cap_t[ncap]  = longint'($time);
        end
        ncap = ncap + 1;
    end

    always @(negedge mdc)
        mdio_i = (ncap >= 48 && ncap < 64) ? phy_val[63 - ncap] : 1'b1;

    // {phy, reg, is_read, write value, phy reply}
    localparam int NVEC = 6;
    localparam logic [42:0] VEC [NVEC] = '{
        {5'h1F, 5'h00, 1'b0, 16'hA5C3, 16'h0000},
        {5'h00, 5'h1F, 1'b1, 16'h0000, 16'h1234},
        {5'h15, 5'h0A, 1'b0, 16'hFFFF, 16'h0000},
        {5'h0A, 5'h15, 1'b1, 16'h0000, 16'h8001},
        {5'h03, 5'h01, 1'b1, 16'h0000, 16'h796D},
        {5'h10, 5'h11, 1'b0, 16'h0000, 16'h0000}
    };

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
        rd_addr = 2'd1;
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        rd_addr = 2'd1;
        #1;
        while (!rd_data[7] && cyc < 30000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
    endtask

    function automatic logic [1:0] exp_bit(int k, logic [4:0] p, logic [4:0] r, logic rd, logic [15:0] wd);
        if (k < 32)       return 2'b11;
        else if (k == 32) return 2'b10;
        else if (k == 33) return 2'b11;
        else if (k == 34) return {1'b1, rd};
        else if (k == 35) return {1'b1, !rd};
        else if (k <= 40) return {1'b1, p[40 - k]};
        else if (k <= 45) return {1'b1, r[45 - k]};
        else if (k >= 64) return 2'b00;
        else if (rd)      return 2'b00;
        else if (k == 46) return 2'b11;
        else if (k == 47) return 2'b10;
        else              return {1'b1, wd[63 - k]};
    endfunction

    function automatic int frame_errs(logic [4:0] p, logic [4:0] r, logic rd, logic [15:0] wd);
        int n = 0;
        for (int k = 0; k < 65; k++) begin
            logic [1:0] e = exp_bit(k, p, r, rd, wd);
            if (cap_oe[k] !== e[1]) n++;
            else if (e[1] && cap_o[k] !== e[0]) n++;
        end
        return n;
    endfunction

    function automatic logic [31:0] ctl_word(logic [4:0] p, logic [4:0] r, logic rd, logic wr, logic go);
        logic [31:0] w = '0;
        w[28:24] = p; w[20:16] = r; w[15] = rd; w[14] = wr; w[11] = go;
        return w;
    endfunction

    task automatic run_txn(logic [4:0] p, logic [4:0] r, logic rd, logic [15:0] wd,
                           logic [15:0] pv, output int cyc);
        logic [31:0] v;
        phy_val = pv;
        mdio_i  = 1'b1;
        reg_write(2'd2, {16'h0, wd});
        ncap = 0;
        reg_write(2'd1, ctl_word(p, r, rd, !rd, 1'b1));
        reg_read(2'd1, v);
        // R3: ready low in the cycle after the launching edge
        check(v[7] == 1'b0, "R3", v, {v[31:8], 1'b0, v[6:0]});
        wait_ready(cyc);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        int cyc, n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        reg_read(2'd0, v); check(v == 32'h0000001D, "R1", v, 32'h1D);
        reg_read(2'd1, v); check(v == 32'h00000080, "R1", v, 32'h80);
        reg_read(2'd3, v); check(v == 32'h0, "R1", v, 32'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", {mdc, mdio_oe}, 0);

        // R11: launch with enable clear does nothing
        ncap = 0;
        reg_write(2'd1, ctl_word(5'h01, 5'h02, 1'b1, 1'b0, 1'b1));
        repeat (200) @(negedge clk);
        reg_read(2'd1, v);
        check(v[7] == 1'b1 && ncap == 0, "R11", {v[7], 8'(ncap)}, {1'b1, 8'h0});

        // enable, divisor 1
        reg_write(2'd0, 32'h41);

        // R2: field placement, no launch bit
        w = ctl_word(5'h15, 5'h0A, 1'b1, 1'b0, 1'b0);
        reg_write(2'd1, w);
        reg_read(2'd1, v);
        check(v == (w | 32'h80), "R2", v, w | 32'h80);
        w = ctl_word(5'h0B, 5'h14, 1'b0, 1'b1, 1'b0);
        reg_write(2'd1, w);
        reg_read(2'd1, v);
        check(v == (w | 32'h80), "R2", v, w | 32'h80);

        // table walk: R4 R5 R6 R8 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [4:0]  p  = VEC[i][42:38];
            logic [4:0]  r  = VEC[i][37:33];
            logic        rd = VEC[i][32];
            logic [15:0] wd = VEC[i][31:16];
            logic [15:0] pv = VEC[i][15:0];
            run_txn(p, r, rd, wd, pv, cyc);
            check(ncap == 65, "R8", ncap, 65);
            n = frame_errs(p, r, rd, wd);
            check(n == 0, rd ? "R4 R6" : "R4 R5", n, 0);
            if (rd) begin
                reg_read(2'd3, v);
                check(v == {16'h0, pv}, "R6", v, {16'h0, pv});
            end
            check(cap_t[2] - cap_t[1] == 32, "R7", 32'(cap_t[2] - cap_t[1]), 32);
        end

        // R7: divisor 3 gives 64 ns mdc period
        reg_write(2'd0, 32'h43);
        run_txn(5'h05, 5'h06, 1'b0, 16'h0F0F, 16'h0, cyc);
        check(cap_t[5] - cap_t[4] == 64, "R7", 32'(cap_t[5] - cap_t[4]), 64);
        check(mdc == 1'b0, "R7", mdc, 0);

        // R9: command written mid-exchange is ignored
        reg_write(2'd0, 32'h41);
        phy_val = 16'hC00C;
        ncap = 0;
        reg_write(2'd1, ctl_word(5'h12, 5'h07, 1'b1, 1'b0, 1'b1));
        repeat (40) @(negedge clk);
        reg_write(2'd1, ctl_word(5'h09, 5'h1C, 1'b0, 1'b1, 1'b1));
        wait_ready(cyc);
        check(ncap == 65, "R9", ncap, 65);
        n = frame_errs(5'h12, 5'h07, 1'b1, 16'h0);
        check(n == 0, "R9", n, 0);
        reg_read(2'd1, v);
        check(v[28:24] == 5'h12 && v[20:16] == 5'h07, "R9", v, ctl_word(5'h12, 5'h07, 1'b1, 1'b0, 1'b0));
        reg_read(2'd3, v);
        check(v == 32'hC00C, "R9", v, 32'hC00C);

        // R10: both or neither opcode bits
        ncap = 0;
        reg_write(2'd1, ctl_word(5'h01, 5'h01, 1'b1, 1'b1, 1'b1));
        reg_read(2'd1, v);
        check(v[7] == 1'b1, "R10", v, 32'h80);
        reg_write(2'd1, ctl_word(5'h01, 5'h01, 1'b0, 1'b0, 1'b1));
        repeat (50) @(negedge clk);
        reg_read(2'd1, v);
        check(v[7] == 1'b1 && ncap == 0, "R10", {v[7], 8'(ncap)}, {1'b1, 8'h0});

        // R12: reset divisor meets the 200 us budget
        reg_write(2'd0, 32'h5D);
        run_txn(5'h02, 5'h03, 1'b0, 16'h1357, 16'h0, cyc);
        check(cyc <= 25000 && ncap == 65, "R12", cyc, 25000);
        check(cap_t[2] - cap_t[1] == 480, "R12", 32'(cap_t[2] - cap_t[1]), 480);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule